// File: doc/BRIEF.md
# Dual-Lane Register Move Unit

This block carries out register-to-register moves for a core that has two identical processing lanes, X and Y. Each lane owns a file of data registers, and a shared bank of system registers sits beside them. Some system registers have a lane-Y twin, and a constant mask inside the block names which ones. The block holds all of this register state. Each cycle it decodes one move request and commits the resulting writes on the next rising clock edge.

A mode input chooses between two kinds of move. In single-lane mode a move reads one register and writes one register, and the lane-select bits place each end in either lane. The condition is judged against lane X flags alone. In paired mode the same move runs in both lanes at once, and each lane judges the condition against its own flags. System-register sources are broadcast to both lanes. A system-register destination takes the lane-Y value only if it has a twin.

A combinational peek port reads any register for observation. Every register comes out of reset holding a fixed identity pattern, so moves can be traced without a separate load path.

Top module: `lane_move_unit`

## Requirements
- R1: After reset, data register i of lane X reads 0x1000_0000+i, of lane Y 0x2000_0000+i, system register i reads 0x3000_0000+i, and the lane-Y twin of a twinned system register i reads 0x4000_0000+i.
- R2: With req_paired=0 a passing move writes exactly one register: source is system register src_idx when req_src_sys=1, else data register src_idx of lane Y (req_src_lane=1) or X (0); destination is system register dst_idx when req_dst_sys=1, else data register dst_idx of the lane named by req_dst_lane.
- R3: With req_paired=0 only flags_x decides the condition; flags_y has no effect.
- R4: With req_paired=1 and data-to-data, lane X copies its src_idx register into its dst_idx register and lane Y does the same in its own file; both lane-select bits are ignored.
- R5: With req_paired=1 the lane X write is gated by the condition on flags_x and every lane Y write by the condition on flags_y, independently.
- R6: With req_paired=1, a system source and data destination writes system register src_idx into data register dst_idx of both lanes.
- R7: With req_paired=1, a data source and a twinned system destination (mask 16'h000F: indices 0 to 3) writes lane X data to the system register and lane Y data to its twin.
- R8: With req_paired=1 and a system destination without a twin, only the lane X write happens; lane Y's value is dropped and we_sys_y stays low.
- R9: Condition code req_cond[2:0]: 0 is always true, 1 to 4 select flag bit 0 to 3, 5 to 7 are always false; req_cond[3]=1 inverts the result.
- R10: Writes commit on the rising edge after the request; a peek in the request cycle returns the old value.
- R11: With req_valid=0 all write strobes are low and no register changes.
- R12: With req_paired=1 system-to-system, system register dst_idx takes system register src_idx under lane X's condition; a twinned destination's twin takes the source's twin (or the source itself when the source has no twin) under lane Y's condition.
- R13: Peeking the lane-Y side of a system register without a twin returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Move request present |
| req_paired | input | 1 | 1 = paired-lane mode, 0 = single-lane mode |
| req_src_sys | input | 1 | Source is in system space |
| req_src_lane | input | 1 | Source lane in single-lane mode (1 = Y) |
| req_src_idx | input | 4 | Source register index |
| req_dst_sys | input | 1 | Destination is in system space |
| req_dst_lane | input | 1 | Destination lane in single-lane mode (1 = Y) |
| req_dst_idx | input | 4 | Destination register index |
| req_cond | input | 4 | Condition code, bit 3 inverts |
| flags_x | input | 4 | Lane X condition flags |
| flags_y | input | 4 | Lane Y condition flags |
| peek_sys | input | 1 | Peek system space |
| peek_lane | input | 1 | Peek lane Y side |
| peek_idx | input | 4 | Peek register index |
| peek_data | output | 32 | Current value of the peeked register |
| we_lane_x | output | 1 | Lane X data file write this cycle |
| we_lane_y | output | 1 | Lane Y data file write this cycle |
| we_sys_x | output | 1 | System register write this cycle |
| we_sys_y | output | 1 | Twin system register write this cycle |

## Verification
In paired mode the lane X write and the lane Y write fall in the same cycle. The bench drives flag patterns in which one lane's condition passes while the other's fails, in both directions and with inverted codes. It checks each write strobe during the request and each of the four register spaces afterwards. A read and a write of the same register also meet in one cycle. This is provoked by moves whose destination is peeked during the request and by back-to-back moves that exchange two registers. The peek must show the old value, and the following move must pick up the value just committed.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

    // Move kind, encoded as {source is system, destination is system}
    typedef enum logic [1:0] {
        MV_DATA_DATA = 2'b00,
        MV_DATA_SYS  = 2'b01,
        MV_SYS_DATA  = 2'b10,
        MV_SYS_SYS   = 2'b11
    } mv_kind_e;

    // Write strobes for the four register spaces
    typedef struct packed {
        logic sys_y;
        logic sys_x;
        logic lane_y;
        logic lane_x;
    } strobe_t;

    localparam int LANES  = 2;
    localparam int LANE_X = 0;
    localparam int LANE_Y = 1;

endpackage

// File: rtl/lmu_cond_eval.sv
module lmu_cond_eval #(
    parameter int NFLAG = 4,
    parameter int SELW  = $clog2(NFLAG + 2)
) (
    input  logic [SELW:0]      cond,
    input  logic [NFLAG-1:0]   flags,
    output logic               pass
);

    logic [SELW-1:0] sel;
    logic            base;

    assign sel = cond[SELW-1:0];

    always_comb begin
        base = (sel == '0);
        for (int k = 0; k < NFLAG; k++) begin
            if (sel == SELW'(k + 1)) begin
                base = flags[k];
            end
        end
        pass = base ^ cond[SELW];
    end

endmodule

// File: rtl/lmu_route.sv
module lmu_route
    import lmu_pkg::*;
#(
    parameter int              W         = 32,
    parameter int              NREG      = 16,
    parameter logic [NREG-1:0] COMP_MASK = 16'h000F,
    localparam int             IW        = $clog2(NREG)
) (
    input  logic          valid,
    input  logic          paired,
    input  logic          src_sys,
    input  logic          src_lane,
    input  logic [IW-1:0] src_idx,
    input  logic          dst_sys,
    input  logic          dst_lane,
    input  logic [IW-1:0] dst_idx,
    input  logic          pass_x,
    input  logic          pass_y,
    input  logic [W-1:0]  rd_x,
    input  logic [W-1:0]  rd_y,
    input  logic [W-1:0]  rd_sx,
    input  logic [W-1:0]  rd_sy,
    output strobe_t       wr_en,
    output logic [W-1:0]  dat_x,
    output logic [W-1:0]  dat_y,
    output logic [W-1:0]  dat_sx,
    output logic [W-1:0]  dat_sy
);

    typedef struct {
        strobe_t      en;
        logic [W-1:0] dx;
        logic [W-1:0] dy;
        logic [W-1:0] dsx;
        logic [W-1:0] dsy;
    } plan_t;

    plan_t     plan_d;
    mv_kind_e  kind;
    logic      src_twin;
    logic      dst_twin;
    logic [W-1:0] single_val;

    assign kind     = mv_kind_e'({src_sys, dst_sys});
    assign src_twin = COMP_MASK[src_idx];
    assign dst_twin = COMP_MASK[dst_idx];

    always_comb begin
        if (src_sys) begin
            single_val = rd_sx;
        end else if (src_lane) begin
            single_val = rd_y;
        end else begin
            single_val = rd_x;
        end
    end

    always_comb begin
        plan_d.en  = '0;
        plan_d.dx  = '0;
        plan_d.dy  = '0;
        plan_d.dsx = '0;
        plan_d.dsy = '0;
        if (valid) begin
            if (!paired) begin
                if (pass_x) begin
                    if (dst_sys) begin
                        plan_d.en.sys_x = 1'b1;
                        plan_d.dsx      = single_val;
                    end else if (dst_lane) begin
                        plan_d.en.lane_y = 1'b1;
                        plan_d.dy        = single_val;
                    end else begin
                        plan_d.en.lane_x = 1'b1;
                        plan_d.dx        = single_val;
                    end
                end
            end else begin
                unique case (kind)
                    MV_DATA_DATA: begin
                        plan_d.en.lane_x = pass_x;
                        plan_d.en.lane_y = pass_y;
                        plan_d.dx        = rd_x;
                        plan_d.dy        = rd_y;
                    end
                    MV_SYS_DATA: begin
                        plan_d.en.lane_x = pass_x;
                        plan_d.en.lane_y = pass_y;
                        plan_d.dx        = rd_sx;
                        plan_d.dy        = rd_sx;
                    end
                    MV_DATA_SYS: begin
                        plan_d.en.sys_x = pass_x;
                        plan_d.en.sys_y = pass_y & dst_twin;
                        plan_d.dsx      = rd_x;
                        plan_d.dsy      = rd_y;
                    end
                    MV_SYS_SYS: begin
                        plan_d.en.sys_x = pass_x;
                        plan_d.en.sys_y = pass_y & dst_twin;
                        plan_d.dsx      = rd_sx;
                        plan_d.dsy      = src_twin ? rd_sy : rd_sx;
                    end
                    default: begin
                        plan_d.en = '0;
                    end
                endcase
            end
        end
    end

    assign wr_en  = plan_d.en;
    assign dat_x  = plan_d.dx;
    assign dat_y  = plan_d.dy;
    assign dat_sx = plan_d.dsx;
    assign dat_sy = plan_d.dsy;

endmodule

// File: rtl/lmu_regbank.sv
module lmu_regbank
    import lmu_pkg::*;
#(
    parameter int              W         = 32,
    parameter int              NREG      = 16,
    parameter logic [NREG-1:0] COMP_MASK = 16'h000F,
    localparam int             IW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  dat_x,
    input  logic [W-1:0]  dat_y,
    input  logic [W-1:0]  dat_sx,
    input  logic [W-1:0]  dat_sy,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_x,
    output logic [W-1:0]  rd_y,
    output logic [W-1:0]  rd_sx,
    output logic [W-1:0]  rd_sy,
    input  logic          peek_sys,
    input  logic          peek_lane,
    input  logic [IW-1:0] peek_idx,
    output logic [W-1:0]  peek_data
);

    localparam logic [3:0] TAG_X  = 4'h1;
    localparam logic [3:0] TAG_Y  = 4'h2;
    localparam logic [3:0] TAG_SX = 4'h3;
    localparam logic [3:0] TAG_SY = 4'h4;

    typedef logic [W-1:0] word_t;

    typedef struct {
        word_t rx [NREG];
        word_t ry [NREG];
        word_t sx [NREG];
        word_t sy [NREG];
    } bank_t;

    bank_t st_d;
    bank_t st_q;
    word_t sy_vis [NREG];

    function automatic word_t seed(input logic [3:0] tag, input int idx);
        return (word_t'(tag) << (W - 4)) | word_t'(idx);
    endfunction

    // Next-state
    always_comb begin
        st_d = st_q;
        if (wr_en.lane_x) begin
            st_d.rx[wr_idx] = dat_x;
        end
        if (wr_en.lane_y) begin
            st_d.ry[wr_idx] = dat_y;
        end
        if (wr_en.sys_x) begin
            st_d.sx[wr_idx] = dat_sx;
        end
        if (wr_en.sys_y && COMP_MASK[wr_idx]) begin
            st_d.sy[wr_idx] = dat_sy;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                st_q.rx[i] <= seed(TAG_X, i);
                st_q.ry[i] <= seed(TAG_Y, i);
                st_q.sx[i] <= seed(TAG_SX, i);
                st_q.sy[i] <= seed(TAG_SY, i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Twin view: only twinned system registers are visible on lane Y
    for (genvar g = 0; g < NREG; g++) begin : g_twin
        if (COMP_MASK[g]) begin : g_has
            assign sy_vis[g] = st_q.sy[g];
        end else begin : g_none
            assign sy_vis[g] = '0;
        end
    end

    assign rd_x  = st_q.rx[rd_idx];
    assign rd_y  = st_q.ry[rd_idx];
    assign rd_sx = st_q.sx[rd_idx];
    assign rd_sy = sy_vis[rd_idx];

    always_comb begin
        unique case ({peek_sys, peek_lane})
            2'b00:   peek_data = st_q.rx[peek_idx];
            2'b01:   peek_data = st_q.ry[peek_idx];
            2'b10:   peek_data = st_q.sx[peek_idx];
            default: peek_data = sy_vis[peek_idx];
        endcase
    end

    AST_LANE_X_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en.lane_x |=> st_q.rx[$past(wr_idx)] == $past(dat_x)); // R10

    AST_LANE_Y_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en.lane_y |=> st_q.ry[$past(wr_idx)] == $past(dat_y)); // R10

    AST_SYS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en.sys_x |=> st_q.sx[$past(wr_idx)] == $past(dat_sx)); // R10

endmodule

// File: rtl/lane_move_unit.sv
module lane_move_unit
    import lmu_pkg::*;
#(
    parameter int              W         = 32,
    parameter int              NREG      = 16,
    parameter int              NFLAG     = 4,
    parameter logic [NREG-1:0] COMP_MASK = 16'h000F,
    localparam int             IW        = $clog2(NREG),
    localparam int             SELW      = $clog2(NFLAG + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_paired,
    input  logic             req_src_sys,
    input  logic             req_src_lane,
    input  logic [IW-1:0]    req_src_idx,
    input  logic             req_dst_sys,
    input  logic             req_dst_lane,
    input  logic [IW-1:0]    req_dst_idx,
    input  logic [SELW:0]    req_cond,
    input  logic [NFLAG-1:0] flags_x,
    input  logic [NFLAG-1:0] flags_y,
    input  logic             peek_sys,
    input  logic             peek_lane,
    input  logic [IW-1:0]    peek_idx,
    output logic [W-1:0]     peek_data,
    output logic             we_lane_x,
    output logic             we_lane_y,
    output logic             we_sys_x,
    output logic             we_sys_y
);

    logic [NFLAG-1:0] lane_flags [LANES];
    logic [LANES-1:0] lane_pass;
    strobe_t          wr_en;
    logic [W-1:0]     rd_x, rd_y, rd_sx, rd_sy;
    logic [W-1:0]     dat_x, dat_y, dat_sx, dat_sy;

    assign lane_flags[LANE_X] = flags_x;
    assign lane_flags[LANE_Y] = flags_y;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        lmu_cond_eval #(
            .NFLAG (NFLAG),
            .SELW  (SELW)
        ) u_cond (
            .cond  (req_cond),
            .flags (lane_flags[ln]),
            .pass  (lane_pass[ln])
        );
    end

    lmu_route #(
        .W         (W),
        .NREG      (NREG),
        .COMP_MASK (COMP_MASK)
    ) u_route (
        .valid    (req_valid),
        .paired   (req_paired),
        .src_sys  (req_src_sys),
        .src_lane (req_src_lane),
        .src_idx  (req_src_idx),
        .dst_sys  (req_dst_sys),
        .dst_lane (req_dst_lane),
        .dst_idx  (req_dst_idx),
        .pass_x   (lane_pass[LANE_X]),
        .pass_y   (lane_pass[LANE_Y]),
        .rd_x     (rd_x),
        .rd_y     (rd_y),
        .rd_sx    (rd_sx),
        .rd_sy    (rd_sy),
        .wr_en    (wr_en),
        .dat_x    (dat_x),
        .dat_y    (dat_y),
        .dat_sx   (dat_sx),
        .dat_sy   (dat_sy)
    );

    lmu_regbank #(
        .W         (W),
        .NREG      (NREG),
        .COMP_MASK (COMP_MASK)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (req_dst_idx),
        .dat_x     (dat_x),
        .dat_y     (dat_y),
        .dat_sx    (dat_sx),
        .dat_sy    (dat_sy),
        .rd_idx    (req_src_idx),
        .rd_x      (rd_x),
        .rd_y      (rd_y),
        .rd_sx     (rd_sx),
        .rd_sy     (rd_sy),
        .peek_sys  (peek_sys),
        .peek_lane (peek_lane),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    assign we_lane_x = wr_en.lane_x;
    assign we_lane_y = wr_en.lane_y;
    assign we_sys_x  = wr_en.sys_x;
    assign we_sys_y  = wr_en.sys_y;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (wr_en == '0)); // R11

    AST_SINGLE_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_paired) |-> $onehot0(wr_en)); // R2

    AST_SINGLE_X_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_paired && !lane_pass[LANE_X]) |-> (wr_en == '0)); // R3

    AST_Y_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_paired && !lane_pass[LANE_Y]) |-> !(we_lane_y || we_sys_y)); // R5

    AST_NO_TWIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_sys_y |-> COMP_MASK[req_dst_idx]); // R8

    AST_BROADCAST_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_paired && req_src_sys && !req_dst_sys && we_lane_x && we_lane_y)
            |-> (dat_x == dat_y)); // R6

endmodule

// File: tb/lane_move_unit_bench.sv
module lane_move_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TWIN = 16'h000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_paired = 1'b0;
    logic        req_src_sys = 1'b0, req_src_lane = 1'b0;
    logic [3:0]  req_src_idx = '0;
    logic        req_dst_sys = 1'b0, req_dst_lane = 1'b0;
    logic [3:0]  req_dst_idx = '0;
    logic [3:0]  req_cond = '0;
    logic [3:0]  flags_x = '0, flags_y = '0;
    logic        peek_sys = 1'b0, peek_lane = 1'b0;
    logic [3:0]  peek_idx = '0;
    logic [31:0] peek_data;
    logic        we_lane_x, we_lane_y, we_sys_x, we_sys_y;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] mx [16], my [16], msx [16], msy [16];

    typedef struct { logic [3:0] s; string tag; } exp_t;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_move_unit u_lane_move_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_paired(req_paired),
        .req_src_sys(req_src_sys), .req_src_lane(req_src_lane), .req_src_idx(req_src_idx),
        .req_dst_sys(req_dst_sys), .req_dst_lane(req_dst_lane), .req_dst_idx(req_dst_idx),
        .req_cond(req_cond), .flags_x(flags_x), .flags_y(flags_y),
        .peek_sys(peek_sys), .peek_lane(peek_lane), .peek_idx(peek_idx),
        .peek_data(peek_data), .we_lane_x(we_lane_x), .we_lane_y(we_lane_y),
        .we_sys_x(we_sys_x), .we_sys_y(we_sys_y)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
        bit b;
        case (c[2:0])
            3'd0:    b = 1'b1;
            3'd1:    b = f[0];
            3'd2:    b = f[1];
            3'd3:    b = f[2];
            3'd4:    b = f[3];
            default: b = 1'b0;
        endcase
        return b ^ c[3];
    endfunction

    // Monitor: compares strobes mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " strobes"}, {28'd0, we_sys_y, we_sys_x, we_lane_y, we_lane_x},
                  {28'd0, e.s});
        end
    end

    task automatic peek_expect(input string tag, input bit s, input bit l, input int i);
        logic [31:0] e;
        peek_sys = s; peek_lane = l; peek_idx = 4'(i);
        #1;
        if (!s) e = l ? my[i] : mx[i];
        else if (!l) e = msx[i];
        else e = TWIN[i] ? msy[i] : 32'd0;
        check(tag, peek_data, e);
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < 2; s++)
            for (int l = 0; l < 2; l++)
                for (int i = 0; i < 16; i++)
                    peek_expect(tag, s[0], l[0], i);
    endtask

    task automatic idle(input string tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_paired = 1'b1; req_src_sys = 1'b0; req_dst_sys = 1'b1;
        req_src_idx = 4'd5; req_dst_idx = 4'd1; req_cond = 4'd0;
        flags_x = 4'hF; flags_y = 4'hF;
        sb.push_back('{4'b0000, tag});
    endtask

    task automatic issue(input string tag, input bit p, input bit ss, input bit sl, input int si,
                         input bit ds, input bit dl, input int di, input logic [3:0] c,
                         input logic [3:0] fx, input logic [3:0] fy);
        bit px, py;
        logic [3:0] s;
        logic [31:0] v, vx, vy, vsx, vsy;
        @(posedge clk); #1;
        req_valid = 1'b1; req_paired = p;
        req_src_sys = ss; req_src_lane = sl; req_src_idx = 4'(si);
        req_dst_sys = ds; req_dst_lane = dl; req_dst_idx = 4'(di);
        req_cond = c; flags_x = fx; flags_y = fy;
        px = cond_ok(c, fx); py = cond_ok(c, fy);
        s = '0; vx = '0; vy = '0; vsx = '0; vsy = '0;
        if (!p) begin
            v = ss ? msx[si] : (sl ? my[si] : mx[si]);
            if (px) begin
                if (ds) begin s[2] = 1'b1; vsx = v; end
                else if (dl) begin s[1] = 1'b1; vy = v; end
                else begin s[0] = 1'b1; vx = v; end
            end
        end else if (!ds) begin
            s[0] = px; s[1] = py;
            vx = ss ? msx[si] : mx[si];
            vy = ss ? msx[si] : my[si];
        end else begin
            s[2] = px; s[3] = py && TWIN[di];
            vsx = ss ? msx[si] : mx[si];
            vsy = ss ? (TWIN[si] ? msy[si] : msx[si]) : my[si];
        end
        sb.push_back('{s, tag});
        // R10: destination still holds the old value during the request
        peek_expect({tag, " R10 old"}, ds, ds ? 1'b0 : (p ? 1'b0 : dl), di);
        if (s[0]) mx[di] = vx;
        if (s[1]) my[di] = vy;
        if (s[2]) msx[di] = vsx;
        if (s[3]) msy[di] = vsy;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mx[i]  = 32'h1000_0000 | i;
            my[i]  = 32'h2000_0000 | i;
            msx[i] = 32'h3000_0000 | i;
            msy[i] = 32'h4000_0000 | i;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1 reset image / R13 untwinned zero");

        // Single-lane moves, every direction (R2)
        issue("R2 X->Y data", 0, 0, 0, 3, 0, 1, 5, 4'd0, 4'h0, 4'h0);
        issue("R2 Y->X data", 0, 0, 1, 7, 0, 0, 2, 4'd0, 4'h0, 4'h0);
        issue("R2 sys->X", 0, 1, 0, 6, 0, 0, 4, 4'd0, 4'h0, 4'h0);
        issue("R2 Y->sys", 0, 0, 1, 8, 1, 0, 10, 4'd0, 4'h0, 4'h0);
        // R3: Y flags must not rescue or block a single-lane move
        issue("R3 X fails Y set", 0, 0, 0, 1, 0, 0, 9, 4'd1, 4'h0, 4'hF);
        issue("R3 X passes Y clear", 0, 0, 0, 1, 0, 1, 9, 4'd2, 4'h2, 4'h0);
        // R9: condition code values
        issue("R9 never code 5", 0, 0, 0, 2, 0, 0, 12, 4'd5, 4'hF, 4'hF);
        issue("R9 inverted never", 0, 0, 0, 2, 0, 0, 12, 4'd13, 4'h0, 4'h0);
        issue("R9 flag3 inverted", 0, 0, 1, 3, 0, 0, 13, 4'd12, 4'h7, 4'h0);
        idle("R11 idle");
        check_all("R2 R3 R9 state");

        // Paired data-to-data with lane bits set (R4) and split conditions (R5)
        issue("R4 both pass", 1, 0, 1, 6, 0, 1, 14, 4'd0, 4'h0, 4'h0);
        issue("R5 X pass Y fail", 1, 0, 0, 7, 0, 0, 15, 4'd3, 4'h4, 4'h0);
        issue("R5 X fail Y pass", 1, 0, 0, 8, 0, 0, 11, 4'd3, 4'h0, 4'h4);
        issue("R5 inverted split", 1, 0, 0, 9, 0, 0, 10, 4'd9, 4'h1, 4'h0);
        // R6: system source broadcast
        issue("R6 sys->data both", 1, 1, 1, 12, 0, 0, 3, 4'd0, 4'h0, 4'h0);
        issue("R6 sys->data Y only", 1, 1, 0, 2, 0, 0, 6, 4'd4, 4'h0, 4'h8);
        // R7 / R8: data to system registers
        issue("R7 twin dest", 1, 0, 0, 5, 1, 0, 2, 4'd0, 4'h0, 4'h0);
        issue("R7 twin dest Y fails", 1, 0, 0, 6, 1, 0, 1, 4'd1, 4'h1, 4'h0);
        issue("R8 no twin dest", 1, 0, 0, 7, 1, 1, 9, 4'd0, 4'h0, 4'h0);
        issue("R8 no twin X fails", 1, 0, 0, 8, 1, 0, 11, 4'd1, 4'h0, 4'h1);
        // R12: system to system
        issue("R12 twin->twin", 1, 1, 0, 1, 1, 0, 3, 4'd0, 4'h0, 4'h0);
        issue("R12 plain->twin", 1, 1, 0, 7, 1, 0, 0, 4'd0, 4'h0, 4'h0);
        issue("R12 twin->plain", 1, 1, 0, 2, 1, 0, 14, 4'd0, 4'h0, 4'h0);
        idle("R11 idle");
        check_all("R4-R8 R12 state");

        // R10: back-to-back exchange through two moves
        issue("R10 move a", 1, 0, 0, 4, 0, 0, 5, 4'd0, 4'h0, 4'h0);
        issue("R10 move b", 1, 0, 0, 5, 0, 0, 4, 4'd0, 4'h0, 4'h0);
        issue("R10 single chain", 0, 0, 1, 4, 0, 0, 4, 4'd0, 4'h0, 4'h0);
        idle("R11 idle");
        idle("R11 idle with fields");
        check_all("R10 R11 state");

        @(posedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule